// File: doc/BRIEF.md
# Hardware Page-Table Walker

This block resolves a translation miss by reading a four-level radix page table from memory. A miss arrives with its virtual page number, address-space tag and access kind. The walker starts at the root table named by a base input, reads one 64-bit entry per level and stops at a terminal entry or at a fault. A successful walk emits a one-cycle fill toward the translation cache, carrying the frame number, the attribute bits of the terminal entry and the page size. After that the core retries its access. A failed walk emits a one-cycle fault and no fill.

Terminal entries may sit above the bottom level, which gives 2 MB and 1 GB mappings. A small cache of pointer entries from the upper levels is tagged by address space and by virtual prefix. On a hit, the walk starts at the deepest table already known. That cache is cleared entirely by a global flush, or only for one address-space tag when that tag is reclaimed. Only one walk runs at a time, and the block holds off new misses with a busy signal.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and after its release with no miss offered, `busy`, `memReqValid`, `fillValid` and `faultValid` are all low.
- R2: A miss offered while `busy` is low is accepted, and `busy` stays high until one cycle after its fill or fault. A miss offered while `busy` is high is ignored: it causes no memory read and no fill or fault.
- R3: The read address is `{tablePpn, index, 3'b000}`. Level 3 (the root) takes its table from `rootPpn` and its index from VPN bits 35:27. Levels 2, 1 and 0 take their index from bits 26:18, 17:9 and 8:0. A cold walk to a 4 KB page makes exactly four reads.
- R4: Entry layout: bit 0 valid, bit 5 terminal, bits 39:12 frame number. A fill carries that frame number, the request VPN and ASID, and `fillAttr = {bit7 global, bit6 dirty, bit4 user, bit3 exec, bit2 write, bit1 read}` of the terminal entry. A level-0 terminal gives `fillSize` 0.
- R5: A terminal entry at level 1 gives `fillSize` 1 (2 MB). One at level 2 gives `fillSize` 2 (1 GB).
- R6: A terminal entry at level 1 whose frame bits 8:0 are not zero, or at level 2 whose frame bits 17:0 are not zero, gives a fault at that level and no fill.
- R7: An entry with bit 0 clear, a terminal entry at level 3, or a non-terminal entry at level 0 gives `faultValid` with `faultLevel` equal to the level that was read, and no fill.
- R8: A valid pointer entry read at level 3, 2 or 1 is cached with the request ASID and VPN prefix. A later miss with the same ASID and prefix starts at the deepest cached table, and so makes fewer reads.
- R9: A cached pointer is used only by a miss carrying the same ASID.
- R10: `flushAll` drops every cached pointer. `flushAsidValid` drops only the pointers tagged with `flushAsid`.
- R11: At most one read is outstanding. `memReqValid` is a one-cycle pulse, and the next pulse follows only after `memRespValid` has returned the previous read.
- R12: `fillValid` and `faultValid` are one-cycle pulses that are never high together. Each comes with `walkAccess` equal to the access kind of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootPpn | input | 28 | Frame number of the root table |
| missValid | input | 1 | Miss request present |
| missVpn | input | 36 | Virtual page number of the miss |
| missAsid | input | 8 | Address-space tag of the miss |
| missAccess | input | 2 | Access kind, echoed on completion |
| busy | output | 1 | A walk is in progress; misses are not taken |
| flushAll | input | 1 | Clear the whole pointer cache |
| flushAsidValid | input | 1 | Clear pointers of one tag |
| flushAsid | input | 8 | Tag to clear |
| memReqValid | output | 1 | One-cycle read request |
| memReqAddr | output | 40 | Byte address of the entry to read |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 64 | Entry returned by memory |
| fillValid | output | 1 | Translation fill pulse |
| fillVpn | output | 36 | VPN of the fill |
| fillAsid | output | 8 | ASID of the fill |
| fillPpn | output | 28 | Frame number of the fill |
| fillAttr | output | 6 | Global, dirty, user, exec, write, read |
| fillSize | output | 2 | 0: 4 KB, 1: 2 MB, 2: 1 GB |
| faultValid | output | 1 | Fault pulse |
| faultLevel | output | 2 | Level at which the walk failed |
| walkAccess | output | 2 | Access kind of the completed walk |

## Verification
A stale or wrongly tagged pointer in the structure cache shows up in the completed walk. The read count drops or grows, or the first read address points into the wrong table, and this is visible at the first read after the miss is accepted. A wrong level count shows up in the `fillSize` or `faultLevel` of that same walk's completion pulse. A hang shows up as `busy` stuck high with no further read. A broken flush shows up on the next walk after it, which finishes with too few reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ENT_VALID = 0;
  localparam int unsigned ENT_RD    = 1;
  localparam int unsigned ENT_WR    = 2;
  localparam int unsigned ENT_EX    = 3;
  localparam int unsigned ENT_USER  = 4;
  localparam int unsigned ENT_LEAF  = 5;
  localparam int unsigned ENT_DIRTY = 6;
  localparam int unsigned ENT_GLOB  = 7;

  typedef struct packed {
    logic loadReq;
    logic loadStart;
    logic issueRead;
    logic stepDown;
    logic insertPwc;
    logic latchDone;
  } ptwStrobes_t;

  typedef struct packed {
    logic       entryValid;
    logic       entryLeaf;
    logic       misaligned;
    logic [1:0] level;
  } ptwDecode_t;
endpackage

// File: rtl/ptw_pwc.sv
module ptw_pwc #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned VPN_W   = 36,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PPN_W   = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VPN_W-1:0]  lookVpn,
  input  logic [ASID_W-1:0] lookAsid,
  output logic              hit,
  output logic [1:0]        hitLevel,
  output logic [PPN_W-1:0]  hitPpn,
  input  logic              insValid,
  input  logic [1:0]        insLevel,
  input  logic [PPN_W-1:0]  insPpn,
  input  logic              flushAll,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid
);
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] entValid;
  logic [ASID_W-1:0]  entAsid  [ENTRIES];
  logic [TAG_W-1:0]   entTag   [ENTRIES];
  logic [1:0]         entLevel [ENTRIES];
  logic [PPN_W-1:0]   entPpn   [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   rrPtr;
  logic [PTR_W-1:0]   victim;
  logic               freeFound;
  logic [TAG_W-1:0]   lookTag;

  assign lookTag = lookVpn[VPN_W-1:IDX_W];

  // Bits of the prefix that a pointer to a table at level lvl must match.
  function automatic logic [TAG_W-1:0] levelMask(input logic [1:0] lvl);
    logic [TAG_W-1:0] m;
    m = '1;
    for (int b = 0; b < int'(TAG_W); b++)
      if (b < int'(lvl) * int'(IDX_W)) m[b] = 1'b0;
    return m;
  endfunction

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : gMatch
    assign match[g] = entValid[g] && (entAsid[g] == lookAsid) &&
                      (((entTag[g] ^ lookTag) & levelMask(entLevel[g])) == '0);
  end

  // Deepest matching table wins.
  always_comb begin
    hit      = 1'b0;
    hitLevel = 2'd3;
    hitPpn   = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (match[i] && (!hit || entLevel[i] < hitLevel)) begin
        hit      = 1'b1;
        hitLevel = entLevel[i];
        hitPpn   = entPpn[i];
      end
    end
  end

  // Lowest free slot first, round-robin otherwise.
  always_comb begin
    freeFound = 1'b0;
    victim    = rrPtr;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        victim    = PTR_W'(i);
        freeFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else if (flushAll) begin
      entValid <= '0;
    end else if (flushAsidValid) begin
      for (int i = 0; i < int'(ENTRIES); i++)
        if (entAsid[i] == flushAsid) entValid[i] <= 1'b0;
    end else if (insValid) begin
      entValid[victim] <= 1'b1;
      if (!freeFound)
        rrPtr <= (rrPtr == PTR_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (insValid && !flushAll && !flushAsidValid) begin
      entAsid[victim]  <= lookAsid;
      entTag[victim]   <= lookTag;
      entLevel[victim] <= insLevel;
      entPpn[victim]   <= insPpn;
    end
  end

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !hit);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned VPN_W  = 36,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PPN_W  = 28,
  parameter int unsigned ACC_W  = 2,
  parameter int unsigned ENT_W  = 64,
  localparam int unsigned PG_OFF = IDX_W + 3,
  localparam int unsigned PA_W   = PPN_W + PG_OFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptwStrobes_t       strobes,
  input  logic [VPN_W-1:0]  missVpn,
  input  logic [ASID_W-1:0] missAsid,
  input  logic [ACC_W-1:0]  missAccess,
  input  logic [PPN_W-1:0]  rootPpn,
  input  logic              pwcHit,
  input  logic [1:0]        pwcLevel,
  input  logic [PPN_W-1:0]  pwcPpn,
  input  logic [ENT_W-1:0]  memRespData,
  output logic [PA_W-1:0]   memReqAddr,
  output ptwDecode_t        decode,
  output logic [VPN_W-1:0]  reqVpn,
  output logic [ASID_W-1:0] reqAsid,
  output logic [1:0]        insLevel,
  output logic [PPN_W-1:0]  insPpn,
  output logic [PPN_W-1:0]  fillPpn,
  output logic [5:0]        fillAttr,
  output logic [1:0]        fillSize,
  output logic [1:0]        faultLevel,
  output logic [ACC_W-1:0]  walkAccess
);
  logic [ACC_W-1:0] reqAccess;
  logic [1:0]       curLevel;
  logic [PPN_W-1:0] curBase;
  logic [IDX_W-1:0] curIdx;
  logic [PPN_W-1:0] entryPpn;
  logic [PPN_W-1:0] resPpn;
  logic [5:0]       resAttr;
  logic [1:0]       resLevel;

  assign curIdx     = reqVpn[int'(curLevel) * int'(IDX_W) +: IDX_W];
  assign memReqAddr = {curBase, curIdx, 3'b000};
  assign entryPpn   = memRespData[PG_OFF +: PPN_W];

  always_comb begin
    decode.entryValid = memRespData[ENT_VALID];
    decode.entryLeaf  = memRespData[ENT_LEAF];
    decode.level      = curLevel;
    case (curLevel)
      2'd1:    decode.misaligned = |entryPpn[IDX_W-1:0];
      2'd2:    decode.misaligned = |entryPpn[2*IDX_W-1:0];
      default: decode.misaligned = 1'b0;
    endcase
  end

  assign insLevel = curLevel - 2'd1;
  assign insPpn   = entryPpn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqVpn    <= '0;
      reqAsid   <= '0;
      reqAccess <= '0;
      curLevel  <= 2'd3;
      curBase   <= '0;
      resPpn    <= '0;
      resAttr   <= '0;
      resLevel  <= '0;
    end else begin
      if (strobes.loadReq) begin
        reqVpn    <= missVpn;
        reqAsid   <= missAsid;
        reqAccess <= missAccess;
      end
      if (strobes.loadStart) begin
        curLevel <= pwcHit ? pwcLevel : 2'd3;
        curBase  <= pwcHit ? pwcPpn : rootPpn;
      end else if (strobes.stepDown) begin
        curLevel <= curLevel - 2'd1;
        curBase  <= entryPpn;
      end
      if (strobes.latchDone) begin
        resPpn   <= entryPpn;
        resAttr  <= {memRespData[ENT_GLOB], memRespData[ENT_DIRTY], memRespData[ENT_USER],
                     memRespData[ENT_EX], memRespData[ENT_WR], memRespData[ENT_RD]};
        resLevel <= curLevel;
      end
    end
  end

  assign fillPpn    = resPpn;
  assign fillAttr   = resAttr;
  assign faultLevel = resLevel;
  assign walkAccess = reqAccess;

  always_comb begin
    case (resLevel)
      2'd1:    fillSize = 2'd1;
      2'd2:    fillSize = 2'd2;
      default: fillSize = 2'd0;
    endcase
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memRespValid,
  input  ptwDecode_t  decode,
  output ptwStrobes_t strobes,
  output logic        busy,
  output logic        memReqValid,
  output logic        fillValid,
  output logic        faultValid
);
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_ISSUE, ST_WAIT, ST_DONE} state_e;

  state_e state, stateNext;
  logic   doneFault;
  logic   walkFault;

  assign walkFault = !decode.entryValid ||
                     (decode.entryLeaf && ((decode.level == 2'd3) || decode.misaligned)) ||
                     (!decode.entryLeaf && (decode.level == 2'd0));

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (missValid) begin
        strobes.loadReq = 1'b1;
        stateNext       = ST_START;
      end
      ST_START: begin
        strobes.loadStart = 1'b1;
        stateNext         = ST_ISSUE;
      end
      ST_ISSUE: begin
        strobes.issueRead = 1'b1;
        stateNext         = ST_WAIT;
      end
      ST_WAIT: if (memRespValid) begin
        if (walkFault || decode.entryLeaf) begin
          strobes.latchDone = 1'b1;
          stateNext         = ST_DONE;
        end else begin
          strobes.stepDown  = 1'b1;
          strobes.insertPwc = 1'b1;
          stateNext         = ST_ISSUE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneFault <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.latchDone) doneFault <= walkFault;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = strobes.issueRead;
  assign fillValid   = (state == ST_DONE) && !doneFault;
  assign faultValid  = (state == ST_DONE) && doneFault;

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !busy) |=> busy);
  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R12
  excl_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fillValid && faultValid));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid || faultValid) |=> !(fillValid || faultValid));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned IDX_W       = 9,
  parameter int unsigned ASID_W      = 8,
  parameter int unsigned PPN_W       = 28,
  parameter int unsigned ACC_W       = 2,
  parameter int unsigned PWC_ENTRIES = 8,
  localparam int unsigned VPN_W = 4 * IDX_W,
  localparam int unsigned PA_W  = PPN_W + IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PPN_W-1:0]  rootPpn,
  input  logic              missValid,
  input  logic [VPN_W-1:0]  missVpn,
  input  logic [ASID_W-1:0] missAsid,
  input  logic [ACC_W-1:0]  missAccess,
  output logic              busy,
  input  logic              flushAll,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid,
  output logic              memReqValid,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRespValid,
  input  logic [63:0]       memRespData,
  output logic              fillValid,
  output logic [VPN_W-1:0]  fillVpn,
  output logic [ASID_W-1:0] fillAsid,
  output logic [PPN_W-1:0]  fillPpn,
  output logic [5:0]        fillAttr,
  output logic [1:0]        fillSize,
  output logic              faultValid,
  output logic [1:0]        faultLevel,
  output logic [ACC_W-1:0]  walkAccess
);
  ptwStrobes_t       strobes;
  ptwDecode_t        decode;
  logic [VPN_W-1:0]  reqVpn;
  logic [ASID_W-1:0] reqAsid;
  logic              pwcHit;
  logic [1:0]        pwcLevel;
  logic [PPN_W-1:0]  pwcPpn;
  logic [1:0]        insLevel;
  logic [PPN_W-1:0]  insPpn;

  ptw_ctrl ctrl_i (
    .clk, .rstN, .missValid, .memRespValid, .decode, .strobes,
    .busy, .memReqValid, .fillValid, .faultValid
  );

  ptw_datapath #(
    .IDX_W(IDX_W), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W), .ACC_W(ACC_W), .ENT_W(64)
  ) dp_i (
    .clk, .rstN, .strobes, .missVpn, .missAsid, .missAccess, .rootPpn,
    .pwcHit, .pwcLevel, .pwcPpn, .memRespData, .memReqAddr, .decode,
    .reqVpn, .reqAsid, .insLevel, .insPpn, .fillPpn, .fillAttr, .fillSize,
    .faultLevel, .walkAccess
  );

  ptw_pwc #(
    .ENTRIES(PWC_ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)
  ) pwc_i (
    .clk, .rstN, .lookVpn(reqVpn), .lookAsid(reqAsid),
    .hit(pwcHit), .hitLevel(pwcLevel), .hitPpn(pwcPpn),
    .insValid(strobes.insertPwc), .insLevel, .insPpn,
    .flushAll, .flushAsidValid, .flushAsid
  );

  assign fillVpn  = reqVpn;
  assign fillAsid = reqAsid;

  // R6
  giga_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillSize == 2'd2) |-> (fillPpn[2*IDX_W-1:0] == '0));
endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] rootPpn = 28'd1;
  logic        missValid = 1'b0;
  logic [35:0] missVpn = '0;
  logic [7:0]  missAsid = '0;
  logic [1:0]  missAccess = '0;
  logic        busy;
  logic        flushAll = 1'b0;
  logic        flushAsidValid = 1'b0;
  logic [7:0]  flushAsid = '0;
  logic        memReqValid;
  logic [39:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [63:0] memRespData = '0;
  logic        fillValid;
  logic [35:0] fillVpn;
  logic [7:0]  fillAsid;
  logic [27:0] fillPpn;
  logic [5:0]  fillAttr;
  logic [1:0]  fillSize;
  logic        faultValid;
  logic [1:0]  faultLevel;
  logic [1:0]  walkAccess;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (.*);

  int checks = 0;
  int errors = 0;
  logic [63:0] mem [8192];
  int   pendCnt = 0;
  logic [39:0] pendAddr = '0;
  int   readCount = 0;
  int   overlapCount = 0;
  logic [39:0] addrLog [4];

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FL = 8'h20, FD = 8'h40, FG = 8'h80;

  function automatic logic [63:0] mkEnt(input logic [27:0] ppn, input logic [7:0] fl);
    return {24'd0, ppn, 4'd0, fl};
  endfunction
  function automatic logic [35:0] mkVpn(input int a, input int b, input int c, input int d);
    return {9'(a), 9'(b), 9'(c), 9'(d)};
  endfunction

  // memory model: two-cycle read latency
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (memReqValid) begin
      if (pendCnt != 0 || memRespValid) overlapCount <= overlapCount + 1;
      addrLog[readCount % 4] <= memReqAddr;
      readCount <= readCount + 1;
      pendCnt   <= 2;
      pendAddr  <= memReqAddr;
    end else if (pendCnt != 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        memRespValid <= 1'b1;
        memRespData  <= (pendAddr[39:16] == '0) ? mem[pendAddr[15:3]] : 64'd0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results of the last walk
  int          wReads;
  bit          wFill, wFault;
  logic [27:0] wPpn;
  logic [5:0]  wAttr;
  logic [1:0]  wSize, wLevel, wAcc;
  logic [35:0] wVpn;
  logic [7:0]  wAsid;

  task automatic runWalk(input logic [35:0] vpn, input logic [7:0] asid, input logic [1:0] acc);
    int start, n;
    @(negedge clk);
    start = readCount;
    missValid = 1'b1; missVpn = vpn; missAsid = asid; missAccess = acc;
    @(negedge clk);
    missValid = 1'b0;
    n = 0;
    while (!(fillValid || faultValid) && n < 300) begin
      @(negedge clk);
      n++;
    end
    wFill = fillValid; wFault = faultValid; wPpn = fillPpn; wAttr = fillAttr;
    wSize = fillSize; wLevel = faultLevel; wAcc = walkAccess; wVpn = fillVpn; wAsid = fillAsid;
    wReads = readCount - start;
    if (n >= 300) check(1'b0, "walk completion timeout", 0, 1);
    @(negedge clk);
    check(!fillValid && !faultValid, "R12 completion is a single pulse", {fillValid, faultValid}, 0);
    @(negedge clk);
    check(!busy, "R2 busy released after completion", busy, 0);
  endtask

  task automatic t_reset();
    check(!busy && !memReqValid && !fillValid && !faultValid, "R1 outputs low in reset",
          {busy, memReqValid, fillValid, faultValid}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !memReqValid && !fillValid && !faultValid, "R1 outputs low after reset",
          {busy, memReqValid, fillValid, faultValid}, 0);
  endtask

  task automatic t_fullWalk();
    runWalk(mkVpn(0, 0, 0, 0), 8'd1, 2'd1);
    check(wReads == 4, "R3 cold 4 KB walk reads four levels", wReads, 4);
    check(wFill && !wFault, "R4 cold walk fills", {wFill, wFault}, 2'b10);
    check(wPpn == 28'h1234, "R4 fill frame", wPpn, 28'h1234);
    check(wAttr == 6'b011111, "R4 fill attributes", wAttr, 6'b011111);
    check(wSize == 2'd0, "R4 size 4 KB", wSize, 0);
    check(wVpn == mkVpn(0, 0, 0, 0) && wAsid == 8'd1, "R4 fill vpn/asid", {wVpn, wAsid}, {mkVpn(0, 0, 0, 0), 8'd1});
    check(wAcc == 2'd1, "R12 access echoed on fill", wAcc, 1);
  endtask

  task automatic t_pwcLeafHit();
    runWalk(mkVpn(0, 0, 0, 1), 8'd1, 2'd0);
    check(wReads == 1, "R8 cached level-0 table skips three reads", wReads, 1);
    check(addrLog[(readCount - 1) % 4] == 40'h5008, "R3 level-0 address", addrLog[(readCount - 1) % 4], 40'h5008);
    check(wFill && wPpn == 28'h5678 && wAttr == 6'b000001, "R4 read-only leaf", {wFill, wPpn, wAttr}, {1'b1, 28'h5678, 6'b000001});
  endtask

  task automatic t_asidSeparation();
    runWalk(mkVpn(0, 0, 0, 0), 8'd2, 2'd0);
    check(wReads == 4, "R9 other ASID does not reuse cached pointers", wReads, 4);
    check(wFill && wAsid == 8'd2, "R9 fill for second ASID", {wFill, wAsid}, {1'b1, 8'd2});
  endtask

  task automatic t_hugePages();
    runWalk(mkVpn(0, 0, 1, 5), 8'd1, 2'd0);
    check(wReads == 1, "R8 walk starts at cached level-1 table", wReads, 1);
    check(wFill && wSize == 2'd1 && wPpn == 28'h200, "R5 2 MB leaf", {wFill, wSize, wPpn}, {1'b1, 2'd1, 28'h200});
    check(wAttr == 6'b100011, "R4 2 MB attributes", wAttr, 6'b100011);
    runWalk(mkVpn(0, 1, 7, 7), 8'd1, 2'd0);
    check(wReads == 1, "R8 walk starts at cached level-2 table", wReads, 1);
    check(wFill && wSize == 2'd2 && wPpn == 28'h40000, "R5 1 GB leaf", {wFill, wSize, wPpn}, {1'b1, 2'd2, 28'h40000});
  endtask

  task automatic t_faults();
    runWalk(mkVpn(0, 0, 2, 0), 8'd1, 2'd2);
    check(wFault && !wFill && wLevel == 2'd1, "R6 misaligned 2 MB leaf faults", {wFault, wFill, wLevel}, {1'b1, 1'b0, 2'd1});
    check(wAcc == 2'd2, "R12 access echoed on fault", wAcc, 2);
    runWalk(mkVpn(0, 0, 0, 2), 8'd1, 2'd0);
    check(wFault && !wFill && wLevel == 2'd0, "R7 invalid level-0 entry", {wFault, wFill, wLevel}, {1'b1, 1'b0, 2'd0});
    runWalk(mkVpn(0, 0, 0, 3), 8'd1, 2'd0);
    check(wFault && wLevel == 2'd0, "R7 pointer at level 0", {wFault, wLevel}, {1'b1, 2'd0});
    runWalk(mkVpn(2, 0, 0, 0), 8'd1, 2'd0);
    check(wFault && wLevel == 2'd3 && wReads == 1, "R7 leaf at root", {wFault, wLevel}, {1'b1, 2'd3});
    runWalk(mkVpn(3, 0, 0, 0), 8'd1, 2'd0);
    check(wFault && !wFill && wLevel == 2'd3, "R7 invalid root entry", {wFault, wFill, wLevel}, {1'b1, 1'b0, 2'd3});
  endtask

  task automatic t_flushAsid();
    @(negedge clk);
    flushAsidValid = 1'b1; flushAsid = 8'd2;
    @(negedge clk);
    flushAsidValid = 1'b0;
    runWalk(mkVpn(0, 0, 0, 1), 8'd1, 2'd0);
    check(wReads == 1, "R10 other ASID keeps its pointers", wReads, 1);
    runWalk(mkVpn(0, 0, 0, 1), 8'd2, 2'd0);
    check(wReads == 4, "R10 reclaimed ASID walks from root", wReads, 4);
    check(wFill && wPpn == 28'h5678, "R10 fill after reclaim", wPpn, 28'h5678);
  endtask

  task automatic t_busyHold();
    int start, n, rd;
    bit sawBusy;
    @(negedge clk);
    start = readCount;
    missValid = 1'b1; missVpn = mkVpn(0, 2, 0, 0); missAsid = 8'd1; missAccess = 2'd0;
    @(negedge clk);
    missValid = 1'b0;
    @(negedge clk);
    sawBusy = 1'b1;
    missValid = 1'b1; missVpn = mkVpn(0, 0, 0, 0); missAsid = 8'd1;
    for (int k = 0; k < 3; k++) begin
      if (!busy) sawBusy = 1'b0;
      @(negedge clk);
    end
    missValid = 1'b0;
    check(sawBusy, "R2 busy held during walk", sawBusy, 1);
    n = 0;
    while (!(fillValid || faultValid) && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(fillValid && fillPpn == 28'h999 && fillVpn == mkVpn(0, 2, 0, 0), "R2 first miss served",
          {fillValid, fillPpn}, {1'b1, 28'h999});
    rd = readCount - start;
    check(rd == 3, "R8 walk starts at cached level-2 table", rd, 3);
    check(addrLog[start % 4] == 40'h2010, "R3 level-2 index from VPN bits 26:18", addrLog[start % 4], 40'h2010);
    check(addrLog[(start + 1) % 4] == 40'h4000 && addrLog[(start + 2) % 4] == 40'h7000, "R3 next-table addresses",
          {addrLog[(start + 1) % 4], addrLog[(start + 2) % 4]}, {40'h4000, 40'h7000});
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (fillValid || faultValid) n++;
    end
    check(n == 0 && readCount - start == 3 && !busy, "R2 miss offered while busy ignored", n, 0);
  endtask

  task automatic t_flushAll();
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
    runWalk(mkVpn(0, 0, 0, 0), 8'd1, 2'd0);
    check(wReads == 4, "R10 global flush forces full walk", wReads, 4);
    check(overlapCount == 0, "R11 no overlapping reads", overlapCount, 0);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    mem[1*512 + 0] = mkEnt(28'd2, FV);
    mem[1*512 + 1] = mkEnt(28'd6, FV);
    mem[1*512 + 2] = mkEnt(28'd0, FV | FR | FL);
    mem[2*512 + 0] = mkEnt(28'd3, FV);
    mem[2*512 + 1] = mkEnt(28'h40000, FV | FR | FW | FD | FL);
    mem[2*512 + 2] = mkEnt(28'd4, FV);
    mem[3*512 + 0] = mkEnt(28'd5, FV);
    mem[3*512 + 1] = mkEnt(28'h200, FV | FR | FW | FG | FL);
    mem[3*512 + 2] = mkEnt(28'h201, FV | FR | FL);
    mem[4*512 + 0] = mkEnt(28'd7, FV);
    mem[5*512 + 0] = mkEnt(28'h1234, FV | FR | FW | FX | FU | FD | FL);
    mem[5*512 + 1] = mkEnt(28'h5678, FV | FR | FL);
    mem[5*512 + 3] = mkEnt(28'd5, FV);
    mem[7*512 + 0] = mkEnt(28'h999, FV | FR | FX | FL);
    t_reset();
    t_fullWalk();
    t_pwcLeafHit();
    t_asidSeparation();
    t_hugePages();
    t_faults();
    t_flushAsid();
    t_busyHold();
    t_flushAll();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule